// File: doc/BRIEF.md
# Step-Down Converter Switch Mode Controller

This block is the digital switch sequencer of a synchronous step-down regulator. It turns clock pulses, comparator flags and mode pins into high-side and low-side gate requests. It chooses among three behaviours on its own: fixed-frequency PWM, a pulse-skipping power-save mode driven by hysteretic output-voltage comparators, and an idle state between power-save bursts. A forced-PWM pin overrides that choice and keeps the converter in PWM. The analog loop, the current sensing and the sawtooth ramp sit outside the block and reach it only as single-bit flags.

Each gate turns on only after both gates have been off for a programmable dead time, counted in fast-clock cycles. An undervoltage flag blocks both gates. A four-step soft-start code sets the switch current limit: code 0 is 60 mA, 1 is 120 mA, 2 is 240 mA and 3 is the normal 480 mA. The code climbs one step every `SS_STEP_CYCLES` fast-clock cycles. It starts again from 0 whenever the block leaves shutdown or undervoltage.

Top module: `buck_mode_ctrl`

## Requirements
- R1: While `enable` is low, the block is in shutdown. From the first edge after `enable` is sampled low, `modeInd` is 2'b00 and `ilimCode` is 0. Both gates are off one edge later.
- R2: While `enable` is high and `underVolt` is low, `ilimCode` equals min(n / `SS_STEP_CYCLES`, 3), where n is the number of edges since the hold was released. Codes 0, 1, 2 and 3 stand for 60, 120, 240 and 480 mA.
- R3: `ilimCode` is held at 0 during undervoltage. The count of R2 starts again when `underVolt` falls or when `enable` rises.
- R4: In PWM (`modeInd` 2'b01), a `cyclePulse` requests the high-side switch and drops the low-side switch. A `rampTrip` or a `curLimit` requests the low-side switch and drops the high-side switch. A pulse in the same cycle as a trip wins.
- R5: In PWM, if no trip arrives before the next `cyclePulse`, `hsGate` stays high without a gap (100% duty).
- R6: `hsGate` and `lsGate` are never high together. A gate turns on only after both gates have been low for exactly `DEAD_CYCLES` edges. A requested gate change appears one edge after the mode state changes.
- R7: With `forcePwm` high and `enable` high, the mode is PWM one edge later, whatever `dcmDetect` and `skipLow` show.
- R8: In PWM with `forcePwm` low, either `dcmDetect` or `skipLow` moves the block to power-save idle (`modeInd` 2'b11) with both gates requested off.
- R9: In power-save idle, `compLow` starts a burst (`modeInd` 2'b10). Within a burst the high-side switch runs until `pfmPeak`, then the low-side switch runs until `nearZero`. If `compHigh` is low at that point, a new high-side pulse follows.
- R10: If `compHigh` is high when `nearZero` ends a low-side phase, the block returns to idle (2'b11) and both gates stay off until `compLow`.
- R11: In any power-save state, `compLow2` returns the block to PWM on the next edge, starting in the low-side phase.
- R12: One edge after `underVolt` is sampled high, both gates are off. The mode state is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cyclePulse | input | 1 | One-cycle strobe at the start of each switching period |
| enable | input | 1 | Converter enable; low means shutdown |
| forcePwm | input | 1 | High keeps the converter in PWM |
| underVolt | input | 1 | Input undervoltage flag; blocks both gates |
| rampTrip | input | 1 | PWM ramp comparator has tripped |
| curLimit | input | 1 | High-side switch current limit exceeded |
| pfmPeak | input | 1 | Power-save peak current reached |
| nearZero | input | 1 | Inductor current near zero |
| dcmDetect | input | 1 | Discontinuous conduction detected |
| skipLow | input | 1 | High-side peak current below skip level |
| compHigh | input | 1 | Output above the upper power-save threshold |
| compLow | input | 1 | Output below the lower power-save threshold |
| compLow2 | input | 1 | Output below the PWM return threshold |
| hsGate | output | 1 | High-side gate request |
| lsGate | output | 1 | Low-side gate request |
| modeInd | output | 2 | 00 shutdown, 01 PWM, 10 power-save burst, 11 power-save idle |
| ilimCode | output | 2 | Soft-start current limit step |

## Verification
The mode indication moves one edge after the input that causes it. A gate turn-off follows one edge after that. A turn-on follows after the full dead time as well. So a PWM pulse gives: low-side still high at the first sample, both gates low for `DEAD_CYCLES` samples, then high-side high. The soft-start code is checked on every edge of a sweep, against min(n/`SS_STEP_CYCLES`,3) counted from the edge where the hold drops. Stimulus is applied just after a rising edge and outputs are sampled 2 ns after the edge, so every expected value is tied to a counted edge.

// File: rtl/buck_pkg.sv
package buck_pkg;
  typedef enum logic [2:0] {
    ST_SHUT, ST_PWM, ST_BURST_HS, ST_BURST_LS, ST_IDLE
  } ctrlState_t;

  typedef enum logic [1:0] {SW_OFF, SW_HS, SW_LS} swReq_t;

  typedef struct packed {
    swReq_t swReq;
    logic   ssHold;
  } ctrlStrobe_t;

  localparam logic [1:0] MODE_OFF   = 2'b00;
  localparam logic [1:0] MODE_PWM   = 2'b01;
  localparam logic [1:0] MODE_BURST = 2'b10;
  localparam logic [1:0] MODE_IDLE  = 2'b11;
endpackage

// File: rtl/buck_ctrl.sv
module buck_ctrl
  import buck_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cyclePulse,
  input  logic        enable,
  input  logic        forcePwm,
  input  logic        underVolt,
  input  logic        rampTrip,
  input  logic        curLimit,
  input  logic        pfmPeak,
  input  logic        nearZero,
  input  logic        dcmDetect,
  input  logic        skipLow,
  input  logic        compHigh,
  input  logic        compLow,
  input  logic        compLow2,
  output ctrlStrobe_t strobe,
  output logic [1:0]  modeInd
);
  ctrlState_t state, stateNext;
  logic hsPhase, hsPhaseNext;

  always_comb begin
    stateNext   = state;
    hsPhaseNext = hsPhase;
    if (!enable) begin
      stateNext   = ST_SHUT;
      hsPhaseNext = 1'b0;
    end else begin
      case (state)
        ST_SHUT: begin
          stateNext   = ST_PWM;
          hsPhaseNext = 1'b0;
        end
        ST_PWM: begin
          if (!forcePwm && (dcmDetect || skipLow)) begin
            stateNext   = ST_IDLE;
            hsPhaseNext = 1'b0;
          end else if (cyclePulse) begin
            hsPhaseNext = 1'b1;
          end else if (rampTrip || curLimit) begin
            hsPhaseNext = 1'b0;
          end
        end
        default: begin
          hsPhaseNext = 1'b0;
          if (forcePwm || compLow2) begin
            stateNext = ST_PWM;
          end else begin
            case (state)
              ST_IDLE:     if (compLow) stateNext = ST_BURST_HS;
              ST_BURST_HS: if (pfmPeak) stateNext = ST_BURST_LS;
              ST_BURST_LS: if (nearZero) stateNext = compHigh ? ST_IDLE : ST_BURST_HS;
              default:     stateNext = ST_SHUT;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_SHUT;
      hsPhase <= 1'b0;
    end else begin
      state   <= stateNext;
      hsPhase <= hsPhaseNext;
    end
  end

  always_comb begin
    strobe.ssHold = !enable || underVolt;
    case (state)
      ST_PWM:      strobe.swReq = hsPhase ? SW_HS : SW_LS;
      ST_BURST_HS: strobe.swReq = SW_HS;
      ST_BURST_LS: strobe.swReq = SW_LS;
      default:     strobe.swReq = SW_OFF;
    endcase
    case (state)
      ST_PWM:                   modeInd = MODE_PWM;
      ST_BURST_HS, ST_BURST_LS: modeInd = MODE_BURST;
      ST_IDLE:                  modeInd = MODE_IDLE;
      default:                  modeInd = MODE_OFF;
    endcase
  end

  // R1
  shut_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> modeInd == MODE_OFF);
  // R7
  force_pwm_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && $past(forcePwm)) |-> modeInd == MODE_PWM);
  // R11
  low2_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && $past(compLow2) && $past(modeInd) != MODE_OFF) |-> modeInd == MODE_PWM);
endmodule

// File: rtl/buck_datapath.sv
module buck_datapath
  import buck_pkg::*;
#(
  parameter int DEAD_CYCLES    = 4,
  parameter int SS_STEP_CYCLES = 256,
  parameter int ILIM_W         = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              underVolt,
  input  ctrlStrobe_t       strobe,
  output logic              hsGate,
  output logic              lsGate,
  output logic [ILIM_W-1:0] ilimCode
);
  localparam int DW = $clog2(DEAD_CYCLES + 1);
  localparam int SW = $clog2(SS_STEP_CYCLES);
  localparam logic [DW-1:0] DEAD_LAST = DW'(DEAD_CYCLES - 1);
  localparam logic [SW-1:0] SS_LAST   = SW'(SS_STEP_CYCLES - 1);
  localparam logic [ILIM_W-1:0] ILIM_TOP = '1;

  logic [DW-1:0] deadCnt;
  logic          bothOff;
  logic          deadDone;
  assign bothOff  = !hsGate && !lsGate;
  assign deadDone = bothOff && (deadCnt == DEAD_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsGate  <= 1'b0;
      lsGate  <= 1'b0;
      deadCnt <= DEAD_LAST;
    end else begin
      if (!bothOff)            deadCnt <= '0;
      else if (!deadDone)      deadCnt <= deadCnt + 1'b1;
      if (underVolt) begin
        hsGate <= 1'b0;
        lsGate <= 1'b0;
      end else begin
        if (hsGate && strobe.swReq != SW_HS) hsGate <= 1'b0;
        if (lsGate && strobe.swReq != SW_LS) lsGate <= 1'b0;
        if (deadDone && strobe.swReq == SW_HS) hsGate <= 1'b1;
        if (deadDone && strobe.swReq == SW_LS) lsGate <= 1'b1;
      end
    end
  end

  logic [SW-1:0] ssCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssCnt    <= '0;
      ilimCode <= '0;
    end else if (strobe.ssHold) begin
      ssCnt    <= '0;
      ilimCode <= '0;
    end else if (ilimCode != ILIM_TOP) begin
      if (ssCnt == SS_LAST) begin
        ssCnt    <= '0;
        ilimCode <= ilimCode + 1'b1;
      end else begin
        ssCnt <= ssCnt + 1'b1;
      end
    end
  end

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hsGate && lsGate));
  // R6
  hs_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsGate) |-> !$past(lsGate));
  // R6
  ls_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lsGate) |-> !$past(hsGate));
  // R12
  uv_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(underVolt) |-> bothOff);
  // R2
  ss_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.ssHold) |-> ($past(ilimCode) == ILIM_TOP) ? (ilimCode == ILIM_TOP)
      : (ilimCode == $past(ilimCode) || ilimCode == $past(ilimCode) + 1'b1));
  // R3
  ss_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.ssHold) |-> ilimCode == '0);
endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl
  import buck_pkg::*;
#(
  parameter int DEAD_CYCLES    = 4,
  parameter int SS_STEP_CYCLES = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cyclePulse,
  input  logic       enable,
  input  logic       forcePwm,
  input  logic       underVolt,
  input  logic       rampTrip,
  input  logic       curLimit,
  input  logic       pfmPeak,
  input  logic       nearZero,
  input  logic       dcmDetect,
  input  logic       skipLow,
  input  logic       compHigh,
  input  logic       compLow,
  input  logic       compLow2,
  output logic       hsGate,
  output logic       lsGate,
  output logic [1:0] modeInd,
  output logic [1:0] ilimCode
);
  ctrlStrobe_t strobe;

  buck_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cyclePulse(cyclePulse), .enable(enable),
    .forcePwm(forcePwm), .underVolt(underVolt), .rampTrip(rampTrip),
    .curLimit(curLimit), .pfmPeak(pfmPeak), .nearZero(nearZero),
    .dcmDetect(dcmDetect), .skipLow(skipLow), .compHigh(compHigh),
    .compLow(compLow), .compLow2(compLow2), .strobe(strobe), .modeInd(modeInd)
  );

  buck_datapath #(
    .DEAD_CYCLES(DEAD_CYCLES), .SS_STEP_CYCLES(SS_STEP_CYCLES), .ILIM_W(2)
  ) dp_i (
    .clk(clk), .rstN(rstN), .underVolt(underVolt), .strobe(strobe),
    .hsGate(hsGate), .lsGate(lsGate), .ilimCode(ilimCode)
  );
endmodule

// File: tb/buck_mode_ctrl_tb.sv
module buck_mode_ctrl_tb_top;
  localparam int DEAD = 2;
  localparam int SSN  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cyclePulse = 0, enable = 0, forcePwm = 0, underVolt = 0, rampTrip = 0;
  logic curLimit = 0, pfmPeak = 0, nearZero = 0, dcmDetect = 0, skipLow = 0;
  logic compHigh = 0, compLow = 0, compLow2 = 0;
  logic hsGate, lsGate;
  logic [1:0] modeInd, ilimCode;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  buck_mode_ctrl #(.DEAD_CYCLES(DEAD), .SS_STEP_CYCLES(SSN)) dut_i (
    .clk(clk), .rstN(rstN), .cyclePulse(cyclePulse), .enable(enable),
    .forcePwm(forcePwm), .underVolt(underVolt), .rampTrip(rampTrip),
    .curLimit(curLimit), .pfmPeak(pfmPeak), .nearZero(nearZero),
    .dcmDetect(dcmDetect), .skipLow(skipLow), .compHigh(compHigh),
    .compLow(compLow), .compLow2(compLow2), .hsGate(hsGate), .lsGate(lsGate),
    .modeInd(modeInd), .ilimCode(ilimCode)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic gates(input string req, input int hs, input int ls);
    chk(req, "hsGate", int'(hsGate), hs);
    chk(req, "lsGate", int'(lsGate), ls);
  endtask

  function automatic int ssExp(input int n);
    return (n / SSN > 3) ? 3 : n / SSN;
  endfunction

  // Request a high-side phase from a low-side phase and follow the dead time
  task automatic hsFromLs(input string req);
    tick();
    gates(req, 0, 1);
    for (int d = 0; d < DEAD; d++) begin
      tick();
      gates(req, 0, 0);
    end
    tick();
    gates(req, 1, 0);
  endtask

  task automatic lsFromHs(input string req);
    tick();
    gates(req, 1, 0);
    for (int d = 0; d < DEAD; d++) begin
      tick();
      gates(req, 0, 0);
    end
    tick();
    gates(req, 0, 1);
  endtask

  initial begin
    tick(3);
    gates("R1", 0, 0);
    chk("R1", "modeInd", modeInd, 0);
    chk("R1", "ilimCode", ilimCode, 0);
    rstN = 1'b1;
    tick(2);
    chk("R1", "modeInd", modeInd, 0);
    gates("R1", 0, 0);

    // R2 soft-start sweep
    enable = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      tick();
      chk("R2", "ilimCode", ilimCode, ssExp(i));
    end
    chk("R4", "modeInd", modeInd, 1);
    gates("R4", 0, 1);

    // R4 PWM cycles with various on times, ramp and current limit alternately
    for (int k = 0; k < 4; k++) begin
      cyclePulse = 1'b1;
      hsFromLs("R4");
      cyclePulse = 1'b0;
      tick(k);
      gates("R4", 1, 0);
      if (k % 2 == 0) rampTrip = 1'b1; else curLimit = 1'b1;
      lsFromHs("R4");
      rampTrip = 1'b0;
      curLimit = 1'b0;
    end

    // R5 full duty across a second pulse
    cyclePulse = 1'b1;
    hsFromLs("R5");
    cyclePulse = 1'b0;
    tick(2);
    cyclePulse = 1'b1;
    tick();
    cyclePulse = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      gates("R5", 1, 0);
    end
    rampTrip = 1'b1;
    lsFromHs("R4");
    rampTrip = 1'b0;

    // R7 forced PWM ignores light-load flags
    forcePwm = 1'b1; dcmDetect = 1'b1; skipLow = 1'b1;
    tick(4);
    chk("R7", "modeInd", modeInd, 1);
    gates("R7", 0, 1);
    forcePwm = 1'b0; skipLow = 1'b0;
    tick();
    chk("R8", "modeInd", modeInd, 3);
    dcmDetect = 1'b0;
    tick();
    gates("R8", 0, 0);

    // R9 burst: HS to peak, LS to zero, again
    compLow = 1'b1;
    tick();
    compLow = 1'b0;
    chk("R9", "modeInd", modeInd, 2);
    tick();
    gates("R9", 1, 0);
    pfmPeak = 1'b1;
    lsFromHs("R9");
    pfmPeak = 1'b0;
    nearZero = 1'b1;
    hsFromLs("R9");
    nearZero = 1'b0;
    chk("R9", "modeInd", modeInd, 2);
    pfmPeak = 1'b1;
    lsFromHs("R9");
    pfmPeak = 1'b0;

    // R10 upper threshold ends the burst
    nearZero = 1'b1; compHigh = 1'b1;
    tick();
    nearZero = 1'b0; compHigh = 1'b0;
    chk("R10", "modeInd", modeInd, 3);
    tick();
    gates("R10", 0, 0);
    tick(5);
    gates("R10", 0, 0);
    chk("R10", "modeInd", modeInd, 3);

    // R11 return to PWM from idle
    compLow2 = 1'b1;
    tick();
    compLow2 = 1'b0;
    chk("R11", "modeInd", modeInd, 1);
    tick();
    gates("R11", 0, 1);

    // R8 via skip level, then R11 from a burst
    skipLow = 1'b1;
    tick();
    skipLow = 1'b0;
    chk("R8", "modeInd", modeInd, 3);
    tick();
    gates("R8", 0, 0);
    compLow = 1'b1;
    tick();
    compLow = 1'b0;
    chk("R9", "modeInd", modeInd, 2);
    compLow2 = 1'b1;
    tick();
    compLow2 = 1'b0;
    chk("R11", "modeInd", modeInd, 1);
    tick(6);
    gates("R11", 0, 1);

    // R12 undervoltage blocks gates, R3 holds soft-start
    underVolt = 1'b1; cyclePulse = 1'b1;
    tick();
    cyclePulse = 1'b0;
    gates("R12", 0, 0);
    chk("R12", "modeInd", modeInd, 1);
    chk("R3", "ilimCode", ilimCode, 0);
    tick(3);
    gates("R12", 0, 0);
    underVolt = 1'b0;
    tick();
    gates("R12", 1, 0);
    chk("R3", "ilimCode", ilimCode, 0);
    for (int i = 2; i <= 20; i++) begin
      tick();
      chk("R3", "ilimCode", ilimCode, ssExp(i));
    end

    // R1 shutdown and R3 restart on enable rise
    enable = 1'b0;
    tick();
    chk("R1", "modeInd", modeInd, 0);
    chk("R1", "ilimCode", ilimCode, 0);
    tick();
    gates("R1", 0, 0);
    enable = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      tick();
      chk("R3", "ilimCode", ilimCode, ssExp(i));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule